// File: doc/BRIEF.md
# Packed Double-to-Single Precision Converter

This block narrows packed IEEE-754 binary64 lanes into packed binary32 lanes within a single pipeline stage. Each operation takes a 256-bit source vector, a 2-bit rounding direction, a 2-bit width/encoding mode and the old contents of the 256-bit destination. It returns the new destination and a five-bit exception summary. In the two 128-bit modes the two low source lanes are converted. In the 256-bit mode all four are converted. The results are packed into the low part of the destination. The bits above are cleared or carried over from the old destination, as the mode dictates.

Operations enter through a valid/ready handshake at one per cycle. The result and flags are registered and held until the consumer takes them. Each lane handles rounding, overflow saturation, gradual underflow, NaN quieting, infinities and signed zeros on its own. The flags of the active lanes are merged into one set per operation.

Top module: `pd2ps_conv`

## Requirements
- R1: In every mode, source bits [63:0] convert into destination bits [31:0] and source bits [127:64] convert into destination bits [63:32]. Mode codes: 00 legacy 128-bit, 01 VEX 128-bit, 10 VEX 256-bit, 11 reserved and treated as 01.
- R2: In mode 10, source bits [191:128] convert into destination bits [95:64] and source bits [255:192] convert into destination bits [127:96], and destination bits [255:128] are zero.
- R3: In mode 00, destination bits [127:64] are zero and destination bits [255:128] equal priorDst[255:128].
- R4: In modes 01 and 11, destination bits [255:64] are zero.
- R5: Inexact results are rounded by rndMode: 00 nearest-even, 01 toward negative infinity, 10 toward positive infinity, 11 toward zero. An inexact result sets the precision flag.
- R6: If a finite result would exceed the largest binary32 magnitude after rounding, it sets overflow and precision. The result is infinity of the source sign when rounding points away from zero in that sign (always under nearest-even). Otherwise it is 0x7F7FFFFF with the source sign.
- R7: A NaN input yields sign, exponent 0xFF, fraction bit 22 set, and fraction bits [21:0] equal to source fraction bits [50:29]. The invalid flag is raised only when the input is signaling, that is when source fraction bit 51 is 0.
- R8: A subnormal binary64 input raises the denormal flag. A result below the binary32 normal range is returned as a correctly rounded subnormal, or as the smallest normal if it rounds up to it. Underflow is raised when the result is tiny before rounding and inexact.
- R9: Infinities and signed zeros convert exactly, with sign kept and no flag.
- R10: excFlags is the OR over the active lanes only, with bit 0 invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow, bit 4 precision.
- R11: inReady equals !outValid || outReady. An accepted operation shows outValid high after the next rising clock edge. While outValid is high and outReady is low, outValid, dstVec and excFlags hold.
- R12: After reset, outValid, dstVec and excFlags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be taken this cycle |
| srcVec | input | 256 | Four packed binary64 source lanes |
| priorDst | input | 256 | Old destination contents |
| rndMode | input | 2 | Rounding direction |
| modeSel | input | 2 | Width/encoding mode |
| outValid | output | 1 | Result held on dstVec/excFlags |
| outReady | input | 1 | Consumer takes the result |
| dstVec | output | 256 | Packed binary32 result with upper bits per mode |
| excFlags | output | 5 | Merged exception flags |

## Verification
The handshake assertions assume that outReady and inValid are stable and known around each rising edge. The data assertions assume that modeSel and priorDst are sampled only in the cycle an operation is taken. The stimulus changes all inputs one time unit after a rising edge and holds them until the next. It parks the source and mode while no operation is offered. The per-lane NaN and flag checks apply to any source value. The mode-dependent checks use only the four defined mode codes.

// File: rtl/pd2ps_pkg.sv
package pd2ps_pkg;

  typedef enum logic [1:0] {
    MODE_L128 = 2'b00,
    MODE_V128 = 2'b01,
    MODE_V256 = 2'b10,
    MODE_RSVD = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic precision;
    logic underflow;
    logic overflow;
    logic denormal;
    logic invalid;
  } flags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic keepUpper;
    logic wideMode;
  } ctrl_t;

endpackage

// File: rtl/pd2ps_lane.sv
module pd2ps_lane
  import pd2ps_pkg::*;
#(
  parameter int D_EXP_W  = 11,
  parameter int D_FRAC_W = 52,
  parameter int S_EXP_W  = 8,
  parameter int S_FRAC_W = 23
) (
  input  logic [D_EXP_W+D_FRAC_W:0] dIn,
  input  logic [1:0]                rnd,
  output logic [S_EXP_W+S_FRAC_W:0] sOut,
  output flags_t                    flg
);
  localparam int D_BIAS   = (1 << (D_EXP_W - 1)) - 1;
  localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
  localparam int BIAS_GAP = D_BIAS - S_BIAS;
  localparam int S_EXP_MAX = (1 << S_EXP_W) - 1;
  localparam int KEEP_W   = S_FRAC_W + 1;
  localparam int EXTRA_W  = KEEP_W + 3;
  localparam int WIDE_W   = D_FRAC_W + 1 + EXTRA_W;
  localparam int SH_CAP   = WIDE_W - 20;
  localparam int SH_W     = $clog2(WIDE_W);
  localparam int ES_W     = D_EXP_W + 2;
  localparam int DROP_LO  = D_FRAC_W - S_FRAC_W;

  logic                sgn;
  logic [D_EXP_W-1:0]  ex;
  logic [D_FRAC_W-1:0] fr;
  assign sgn = dIn[D_EXP_W+D_FRAC_W];
  assign ex  = dIn[D_EXP_W+D_FRAC_W-1:D_FRAC_W];
  assign fr  = dIn[D_FRAC_W-1:0];

  logic expAllOnes, expZero;
  assign expAllOnes = &ex;
  assign expZero    = ~|ex;

  // single-precision biased exponent before rounding
  logic signed [ES_W-1:0] esB;
  assign esB = $signed({2'b00, (expZero ? D_EXP_W'(1) : ex)}) - ES_W'(BIAS_GAP);

  logic tiny;
  assign tiny = (esB < $signed(ES_W'(1)));

  logic [ES_W-1:0] shFull;
  logic [SH_W-1:0] shAmt;
  assign shFull = tiny ? ES_W'($signed(ES_W'(1)) - esB) : '0;
  assign shAmt  = (shFull > ES_W'(SH_CAP)) ? SH_W'(SH_CAP) : shFull[SH_W-1:0];

  logic [WIDE_W-1:0] wide, shifted, lostMask;
  assign wide     = {~expZero, fr, {EXTRA_W{1'b0}}};
  assign shifted  = wide >> shAmt;
  assign lostMask = (WIDE_W'(1) << shAmt) - WIDE_W'(1);

  logic [KEEP_W-1:0] kept;
  logic guardBit, stickyBit, inexact;
  assign kept      = shifted[WIDE_W-1 -: KEEP_W];
  assign guardBit  = shifted[WIDE_W-1-KEEP_W];
  assign stickyBit = (|shifted[WIDE_W-2-KEEP_W:0]) | (|(wide & lostMask));
  assign inexact   = guardBit | stickyBit;

  logic incr;
  always_comb begin
    unique case (rnd)
      RND_NEAR: incr = guardBit & (stickyBit | kept[0]);
      RND_DOWN: incr = sgn & inexact;
      RND_UP:   incr = ~sgn & inexact;
      default:  incr = 1'b0;
    endcase
  end

  logic [KEEP_W:0] sum;
  assign sum = {1'b0, kept} + {{KEEP_W{1'b0}}, incr};

  logic signed [ES_W-1:0] expOut;
  logic ovf, toInf;
  assign expOut = esB + $signed({{(ES_W-1){1'b0}}, sum[KEEP_W]});
  assign ovf    = ~tiny && (expOut >= $signed(ES_W'(S_EXP_MAX)));
  assign toInf  = (rnd == RND_NEAR) || (rnd == RND_DOWN && sgn) || (rnd == RND_UP && ~sgn);

  always_comb begin
    flg  = '0;
    sOut = '0;
    if (expAllOnes) begin
      if (fr == '0) begin
        sOut = {sgn, {S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}};
      end else begin
        sOut = {sgn, {S_EXP_W{1'b1}}, 1'b1, fr[D_FRAC_W-2:DROP_LO]};
        flg.invalid = ~fr[D_FRAC_W-1];
      end
    end else if (expZero && fr == '0) begin
      sOut = {sgn, {(S_EXP_W+S_FRAC_W){1'b0}}};
    end else begin
      flg.denormal  = expZero;
      flg.precision = inexact;
      if (tiny) begin
        // exponent field and fraction come straight from the sum
        sOut = {sgn, {(S_EXP_W-1){1'b0}}, sum[KEEP_W-1:0]};
        flg.underflow = inexact;
      end else if (ovf) begin
        flg.overflow  = 1'b1;
        flg.precision = 1'b1;
        sOut = toInf ? {sgn, {S_EXP_W{1'b1}}, {S_FRAC_W{1'b0}}}
                     : {sgn, {(S_EXP_W-1){1'b1}}, 1'b0, {S_FRAC_W{1'b1}}};
      end else begin
        sOut = {sgn, expOut[S_EXP_W-1:0], sum[S_FRAC_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/pd2ps_ctrl.sv
module pd2ps_ctrl
  import pd2ps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       outReady,
  input  logic [1:0] modeSel,
  output logic       inReady,
  output logic       outValid,
  output ctrl_t      ctl
);
  logic accept;
  assign inReady = ~outValid | outReady;
  assign accept  = inValid & inReady;

  assign ctl.capture   = accept;
  assign ctl.keepUpper = (modeSel == MODE_L128);
  assign ctl.wideMode  = (modeSel == MODE_V256);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          outValid <= 1'b0;
    else if (accept)     outValid <= 1'b1;
    else if (outReady)   outValid <= 1'b0;
  end

  a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> outValid);

  a_r11_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady |=> outValid);

endmodule

// File: rtl/pd2ps_datapath.sv
module pd2ps_datapath
  import pd2ps_pkg::*;
#(
  parameter int LANE_COUNT = 4,
  parameter int D_W        = 64,
  parameter int S_W        = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_t                 ctl,
  input  logic [LANE_COUNT*D_W-1:0] srcVec,
  input  logic [LANE_COUNT*D_W-1:0] priorDst,
  input  logic [1:0]            rndMode,
  output logic [LANE_COUNT*D_W-1:0] dstVec,
  output logic [4:0]            excFlags
);
  localparam int VEC_W    = LANE_COUNT * D_W;
  localparam int NARROW_W = LANE_COUNT * S_W;
  localparam int HALF     = LANE_COUNT / 2;

  logic [S_W-1:0]        laneOut [LANE_COUNT];
  flags_t                laneFlg [LANE_COUNT];
  logic [LANE_COUNT-1:0] laneActive;

  for (genvar g = 0; g < LANE_COUNT; g++) begin : gLane
    pd2ps_lane uLane (
      .dIn  (srcVec[g*D_W +: D_W]),
      .rnd  (rndMode),
      .sOut (laneOut[g]),
      .flg  (laneFlg[g])
    );
    if (g < HALF) begin : gLow
      assign laneActive[g] = 1'b1;
    end else begin : gHigh
      assign laneActive[g] = ctl.wideMode;
    end

    always_comb begin
      if (laneFlg[g].overflow)  a_r6_ovf_precision: assert (laneFlg[g].precision);
      if (laneFlg[g].underflow) a_r8_unf_precision: assert (laneFlg[g].precision);
      if ((&srcVec[g*D_W+52 +: 11]) && (|srcVec[g*D_W +: 52]))
        a_r7_nan_quiet: assert (laneOut[g][30:22] == 9'h1FF);
    end
  end

  logic [NARROW_W-1:0] narrow;
  flags_t              flagsAcc;
  always_comb begin
    narrow   = '0;
    flagsAcc = '0;
    for (int i = 0; i < LANE_COUNT; i++) begin
      if (laneActive[i]) begin
        narrow[i*S_W +: S_W] = laneOut[i];
        flagsAcc = flags_t'(flagsAcc | laneFlg[i]);
      end
    end
  end

  logic [VEC_W-NARROW_W-1:0] upper;
  assign upper = ctl.keepUpper ? priorDst[VEC_W-1:NARROW_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dstVec   <= '0;
      excFlags <= '0;
    end else if (ctl.capture) begin
      dstVec   <= {upper, narrow};
      excFlags <= flagsAcc;
    end
  end

endmodule

// File: rtl/pd2ps_conv.sv
module pd2ps_conv
  import pd2ps_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  output logic         inReady,
  input  logic [255:0] srcVec,
  input  logic [255:0] priorDst,
  input  logic [1:0]   rndMode,
  input  logic [1:0]   modeSel,
  output logic         outValid,
  input  logic         outReady,
  output logic [255:0] dstVec,
  output logic [4:0]   excFlags
);
  ctrl_t ctl;

  pd2ps_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .outReady (outReady),
    .modeSel  (modeSel),
    .inReady  (inReady),
    .outValid (outValid),
    .ctl      (ctl)
  );

  pd2ps_datapath #(.LANE_COUNT(4)) uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .srcVec   (srcVec),
    .priorDst (priorDst),
    .rndMode  (rndMode),
    .dstVec   (dstVec),
    .excFlags (excFlags)
  );

  a_r11_stable_out: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && !outReady |=> $stable(dstVec) && $stable(excFlags));

  a_r3_keep_upper: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && modeSel == MODE_L128 |=>
      dstVec[255:128] == $past(priorDst[255:128]) && dstVec[127:64] == '0);

  a_r2_wide_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && modeSel == MODE_V256 |=> dstVec[255:128] == '0);

  a_r4_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && inReady && (modeSel == MODE_V128 || modeSel == MODE_RSVD) |=>
      dstVec[255:64] == '0);

endmodule

// File: tb/pd2ps_conv_test.sv
module pd2ps_conv_test;
  timeunit 1ns;
  timeprecision 1ps;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [255:0] srcVec = '0;
  logic [255:0] priorDst = '0;
  logic [1:0]   rndMode = '0;
  logic [1:0]   modeSel = '0;
  logic         outValid;
  logic         outReady = 1'b1;
  logic [255:0] dstVec;
  logic [4:0]   excFlags;

  always #4 clk = ~clk;

  pd2ps_conv uut (.*);

  typedef struct {
    logic [255:0] dst;
    logic [4:0]   flags;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0;
  int   checks = 0;
  int   readyMode = 0;
  int   cyc = 0;
  logic holdArmed = 1'b0;
  logic [255:0] heldDst;
  logic [4:0]   heldFlags;

  localparam logic [63:0] ONE  = 64'h3FF0000000000000;
  localparam logic [63:0] M25  = 64'hC004000000000000;
  localparam logic [63:0] SNAN = 64'h7FF0000000000001;
  localparam logic [63:0] BIG  = 64'h7E37E43C8800759C;
  localparam logic [63:0] NBIG = 64'hFE37E43C8800759C;
  localparam logic [63:0] HALF = 64'h3FF0000010000000;
  localparam logic [63:0] HALFP= 64'h3FF0000010000001;
  localparam logic [63:0] ODDH = 64'h3FF0000030000000;
  localparam logic [63:0] NHP  = 64'hBFF0000010000001;
  localparam logic [63:0] PRIOR= {4{64'hA5A5_5A5A_C3C3_3C3C}};

  task automatic check(input logic ok, input string what, input logic [255:0] act, input logic [255:0] exv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exv);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 outReady = (readyMode == 0) || (cyc % 3 != 0);
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (holdArmed) begin
        check(outValid, "R11 stall valid", {255'd0, outValid}, 256'd1);
        check(dstVec == heldDst && excFlags == heldFlags, "R11 stall data",
              dstVec, heldDst);
      end
      holdArmed = outValid && !outReady;
      heldDst   = dstVec;
      heldFlags = excFlags;
      if (outValid && outReady) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 unexpected result", dstVec, '0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(dstVec == e.dst, {e.tag, " dst"}, dstVec, e.dst);
          check(excFlags == e.flags, {e.tag, " flags"}, {251'd0, excFlags}, {251'd0, e.flags});
        end
      end
    end
  end

  task automatic sendOp(input logic [1:0] mode, input logic [1:0] rnd,
                        input logic [255:0] src, input logic [127:0] lanes,
                        input logic [19:0] lflags, input logic [255:0] prior,
                        input string tag);
    exp_t e;
    int act;
    act = (mode == 2'b10) ? 4 : 2;
    e.dst = '0;
    e.flags = '0;
    for (int i = 0; i < 4; i++) begin
      if (i < act) begin
        e.dst[i*32 +: 32] = lanes[i*32 +: 32];
        e.flags = e.flags | lflags[i*5 +: 5];
      end
    end
    if (mode == 2'b00) e.dst[255:128] = prior[255:128];
    e.tag = tag;
    @(posedge clk);
    #1;
    srcVec = src; priorDst = prior; rndMode = rnd; modeSel = mode; inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady == (!outValid || outReady)) checks++;
      else begin
        errors++;
        $display("FAIL R11 inReady actual=%b expected=%b", inReady, !outValid || outReady);
      end
      if (inReady) break;
    end
    @(posedge clk);
    q.push_back(e);
    #1 inValid = 1'b0;
    @(negedge clk);
    check(outValid, {tag, " R11 latency"}, {255'd0, outValid}, 256'd1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!outValid && dstVec == '0 && excFlags == '0, "R12 reset", dstVec, '0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    // lane mapping and upper handling
    sendOp(2'b00, 2'b00, {SNAN, SNAN, M25, ONE}, {32'h0, 32'h0, 32'hC0200000, 32'h3F800000},
           20'h0, PRIOR, "R1 R3 R10 legacy");
    sendOp(2'b01, 2'b00, {SNAN, SNAN, M25, ONE}, {32'h0, 32'h0, 32'hC0200000, 32'h3F800000},
           20'h0, PRIOR, "R1 R4 R10 vex128");
    sendOp(2'b11, 2'b00, {BIG, SNAN, ONE, M25}, {32'h0, 32'h0, 32'h3F800000, 32'hC0200000},
           20'h0, PRIOR, "R4 reserved mode");
    sendOp(2'b10, 2'b00, {64'h7FF0000000000000, 64'h8000000000000000, M25, ONE},
           {32'h7F800000, 32'h80000000, 32'hC0200000, 32'h3F800000}, 20'h0, PRIOR, "R2 R9 vex256");

    // rounding directions
    sendOp(2'b10, 2'b00, {NHP, ODDH, HALFP, HALF},
           {32'hBF800001, 32'h3F800002, 32'h3F800001, 32'h3F800000}, {4{5'h10}}, PRIOR, "R5 nearest");
    sendOp(2'b10, 2'b10, {NHP, ODDH, HALFP, HALF},
           {32'hBF800000, 32'h3F800002, 32'h3F800001, 32'h3F800001}, {4{5'h10}}, PRIOR, "R5 up");
    sendOp(2'b10, 2'b01, {NHP, ODDH, HALFP, HALF},
           {32'hBF800001, 32'h3F800001, 32'h3F800000, 32'h3F800000}, {4{5'h10}}, PRIOR, "R5 down");
    sendOp(2'b10, 2'b11, {NHP, ODDH, HALFP, HALF},
           {32'hBF800000, 32'h3F800001, 32'h3F800000, 32'h3F800000}, {4{5'h10}}, PRIOR, "R5 zero");

    // overflow
    sendOp(2'b10, 2'b00, {64'h47EFFFFFE0000000, 64'h47EFFFFFF0000000, NBIG, BIG},
           {32'h7F7FFFFF, 32'h7F800000, 32'hFF800000, 32'h7F800000},
           {5'h00, 5'h14, 5'h14, 5'h14}, PRIOR, "R6 nearest");
    sendOp(2'b10, 2'b11, {64'h47EFFFFFE0000000, 64'h47EFFFFFF0000000, NBIG, BIG},
           {32'h7F7FFFFF, 32'h7F7FFFFF, 32'hFF7FFFFF, 32'h7F7FFFFF},
           {5'h00, 5'h10, 5'h14, 5'h14}, PRIOR, "R6 zero");
    sendOp(2'b10, 2'b10, {64'h47EFFFFFE0000000, 64'h47EFFFFFF0000000, NBIG, BIG},
           {32'h7F7FFFFF, 32'h7F800000, 32'hFF7FFFFF, 32'h7F800000},
           {5'h00, 5'h14, 5'h14, 5'h14}, PRIOR, "R6 up");
    sendOp(2'b01, 2'b01, {ONE, ONE, NBIG, BIG}, {32'h0, 32'h0, 32'hFF800000, 32'h7F7FFFFF},
           {5'h0, 5'h0, 5'h14, 5'h14}, PRIOR, "R6 down");

    // NaN
    sendOp(2'b10, 2'b00, {64'h7FF0000000000000, 64'hFFF8000000000000, 64'h7FF4000000000000, SNAN},
           {32'h7F800000, 32'hFFC00000, 32'h7FE00000, 32'h7FC00000},
           {5'h00, 5'h00, 5'h01, 5'h01}, PRIOR, "R7 signaling");
    sendOp(2'b01, 2'b00, {BIG, BIG, 64'h7FF8000000000123, 64'hFFF8000000000000},
           {32'h0, 32'h0, 32'h7FC00000, 32'hFFC00000}, 20'h0, PRIOR, "R7 R10 quiet");

    // tiny results
    sendOp(2'b10, 2'b00, {64'h380FFFFFF0000000, 64'h3800000000000000, 64'h36A0000000000000, 64'h0000000000000001},
           {32'h00800000, 32'h00400000, 32'h00000001, 32'h00000000},
           {5'h18, 5'h00, 5'h00, 5'h1A}, PRIOR, "R8 nearest");
    sendOp(2'b01, 2'b10, {ONE, ONE, 64'h8000000000000001, 64'h0000000000000001},
           {32'h0, 32'h0, 32'h80000000, 32'h00000001}, {5'h0, 5'h0, 5'h1A, 5'h1A}, PRIOR, "R8 up");
    sendOp(2'b01, 2'b01, {ONE, ONE, 64'h8000000000000001, 64'h0000000000000001},
           {32'h0, 32'h0, 32'h80000001, 32'h00000000}, {5'h0, 5'h0, 5'h1A, 5'h1A}, PRIOR, "R8 down");
    sendOp(2'b01, 2'b00, {BIG, BIG, 64'h3800000000000000, 64'h36A0000000000000},
           {32'h0, 32'h0, 32'h00400000, 32'h00000001}, 20'h0, PRIOR, "R8 exact tiny");

    // signed zeros, infinities, active-lane flag merge
    sendOp(2'b10, 2'b01, {64'hFFF0000000000000, 64'h7FF0000000000000, 64'h8000000000000000, 64'h0},
           {32'hFF800000, 32'h7F800000, 32'h80000000, 32'h00000000}, 20'h0, '0, "R9 specials");
    sendOp(2'b00, 2'b00, {BIG, BIG, 64'h0000000000000001, SNAN},
           {32'h0, 32'h0, 32'h00000000, 32'h7FC00000}, {5'h14, 5'h14, 5'h1A, 5'h01}, ~PRIOR, "R10 merge");

    // backpressure
    readyMode = 1;
    for (int k = 0; k < 6; k++) begin
      sendOp(2'(k % 3), 2'b00, {BIG, M25, HALFP, ONE},
             {32'h7F800000, 32'hC0200000, 32'h3F800001, 32'h3F800000},
             {5'h14, 5'h00, 5'h10, 5'h00}, PRIOR, "R11 stall");
    end
    readyMode = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0 && !outValid, "R11 drain", {255'd0, outValid}, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule